// File: doc/BRIEF.md
# Analog Pin Boundary Module Controller

This block is the digital half of the boundary cell that sits on one analog pin of a mixed-signal scan chain. It holds four scan cells per pin (calibrate, control, data1 and data2). These cells shift serially between `scan_in` and `scan_out` and are copied into an applied register on an update strobe. The block decodes the applied cells together with the active test instruction into six switch enables. Five of them connect the pin to the low reference, the high reference, the quiet reference ground, analog bus 1 (stimulus current) and analog bus 2 (voltage monitor). The sixth opens the path to the pin's core. A comparator output from the pin is synchronized and captured into the data1 cell, so that the pin level can be read back as one bit.

The controller is built around a mode state machine with six states: FUNC, SAMPLE, EXTEST, PROBE, CLAMP and HIGHZ. Every clock the state register loads the state selected by the instruction input. The transitions are FUNC/SAMPLE/EXTEST/PROBE/CLAMP/HIGHZ to any state, and an unknown code falls back to FUNC. A separate output process registers the switch enables from the state and the applied cells. In CLAMP it holds the bus and reference enables frozen. Only a single reference source may be enabled at a time. A request for more than one of them is suppressed and flagged.

Top module: `apin_bsm_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, every switch enable, `drv_err` and `scan_out` are 0, so the pin is connected to its core and every test switch is open.
- R2: With `shift_en` high, each clock moves the chain one place in the order `scan_in` → calibrate → control → data1 → data2 → `scan_out`. `scan_out` always shows the data2 cell.
- R3: `update_en` copies the four scan cells into the applied register on its clock edge. The switch enables reflect the new cells at the following edge. Shifting without an update leaves the enables unchanged.
- R4: `capture_en` loads the data1 scan cell with the pin comparator bit (1 when `cmp_hi` is high), after a two-flop synchronizer. The other three scan cells reload from the applied register. If capture and update share an edge, both act on their pre-edge values.
- R5: Instruction code 2 (EXTEST) drives `en_core_dis` from control. It drives `en_vl` = control AND NOT data1, `en_vh` = control AND data1, `en_vg` = calibrate, and `en_ab1` = `en_ab2` = data2.
- R6: Instruction code 5 (HIGHZ) sets `en_core_dis` to 1 and all five connection enables to 0.
- R7: Instruction code 4 (CLAMP) sets `en_core_dis` to 1 and holds the five connection enables at the values they had on entry, whatever updates occur. Leaving CLAMP resumes normal decoding.
- R8: Instruction code 3 (PROBE) keeps the core connected (`en_core_dis` = 0) and forces the reference enables to 0. It drives `en_ab1` and `en_ab2` from data2.
- R9: Instruction codes 0 (FUNC) and 1 (SAMPLE), and the unused codes 6 and 7, leave the core connected and every test switch open.
- R10: If more than one of `en_vl`, `en_vh` and `en_vg` would be requested, all three are forced to 0 and `drv_err` is 1. The bus enables and `en_core_dis` are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr | input | 3 | Active instruction code |
| shift_en | input | 1 | Shift the scan cells one place |
| capture_en | input | 1 | Capture the comparator bit and applied cells |
| update_en | input | 1 | Copy the scan cells to the applied register |
| scan_in | input | 1 | Serial scan input |
| cmp_hi | input | 1 | Pin comparator output, asynchronous |
| scan_out | output | 1 | Serial scan output (data2 cell) |
| en_core_dis | output | 1 | Open the pin-to-core path |
| en_vl | output | 1 | Connect the pin to the low reference |
| en_vh | output | 1 | Connect the pin to the high reference |
| en_vg | output | 1 | Connect the pin to the reference ground |
| en_ab1 | output | 1 | Connect the pin to analog bus 1 |
| en_ab2 | output | 1 | Connect the pin to analog bus 2 |
| drv_err | output | 1 | More than one reference source was requested |

## Verification
Capture and update can fall on the same clock edge. When they do, the scan cells and the applied register exchange contents, and the data1 cell takes the comparator bit. The bench provokes this by shifting one pattern into the cells while a different pattern is applied, with the comparator held high, and then pulsing both strobes together. It judges the result from two sides. The switch enables must follow the freshly shifted pattern. The chain, read back serially, must hold the old applied pattern with data1 replaced by 1.

// File: rtl/apin_pkg.sv
package apin_pkg;

    localparam int unsigned APIN_NCELL = 4;

    typedef enum logic [2:0] {
        M_FUNC   = 3'd0,
        M_SAMPLE = 3'd1,
        M_EXTEST = 3'd2,
        M_PROBE  = 3'd3,
        M_CLAMP  = 3'd4,
        M_HIGHZ  = 3'd5
    } apin_mode_e;

    // Bit 3 is the cell nearest scan_in, bit 0 feeds scan_out.
    typedef struct packed {
        logic cal;
        logic ctl;
        logic d1;
        logic d2;
    } apin_cells_t;

    typedef struct packed {
        logic core_dis;
        logic vl;
        logic vh;
        logic vg;
        logic ab1;
        logic ab2;
    } apin_sw_t;

endpackage

// File: rtl/apin_sync.sv
module apin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] stg;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[i] <= 1'b0;
                else        stg[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[i] <= 1'b0;
                else        stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/apin_scan_cells.sv
module apin_scan_cells
    import apin_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        shift_en,
    input  logic        capture_en,
    input  logic        update_en,
    input  logic        scan_in,
    input  logic        dig_in,
    output logic        scan_out,
    output apin_cells_t applied
);
    localparam int unsigned LAST = APIN_NCELL - 1;

    apin_cells_t chain_q;
    apin_cells_t upd_q;

    // Capture has priority over shift; update acts on pre-edge cells.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else if (capture_en) begin
            chain_q.cal <= upd_q.cal;
            chain_q.ctl <= upd_q.ctl;
            chain_q.d1  <= dig_in;
            chain_q.d2  <= upd_q.d2;
        end else if (shift_en) begin
            chain_q <= {scan_in, chain_q[LAST:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         upd_q <= '0;
        else if (update_en) upd_q <= chain_q;
    end

    assign scan_out = chain_q.d2;
    assign applied  = upd_q;

    // R2: one shift moves the data1 cell onto scan_out
    p_shift_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !capture_en) |=> (scan_out == $past(chain_q.d1)));

    // R4: capture loads data1 with the digitized pin bit
    p_capture_d1_r4: assert property (@(posedge clk) disable iff (!rst_n)
        capture_en |=> (chain_q.d1 == $past(dig_in)));

    // R3: applied cells change only on an update
    p_upd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !update_en |=> $stable(upd_q));
endmodule

// File: rtl/apin_sw_decode.sv
module apin_sw_decode
    import apin_pkg::*;
(
    input  apin_mode_e  mode,
    input  apin_cells_t cells,
    output apin_sw_t    req,
    output logic        conflict
);
    apin_sw_t raw;

    always_comb begin
        raw = '0;
        unique case (mode)
            M_EXTEST: begin
                raw.core_dis = cells.ctl;
                raw.vl       = cells.ctl & ~cells.d1;
                raw.vh       = cells.ctl &  cells.d1;
                raw.vg       = cells.cal;
                raw.ab1      = cells.d2;
                raw.ab2      = cells.d2;
            end
            M_PROBE: begin
                raw.ab1 = cells.d2;
                raw.ab2 = cells.d2;
            end
            M_CLAMP, M_HIGHZ: begin
                raw.core_dis = 1'b1;
            end
            default: begin
                raw = '0;
            end
        endcase
    end

    always_comb begin
        conflict = ($countones({raw.vl, raw.vh, raw.vg}) > 1);
        req      = raw;
        if (conflict) begin
            req.vl = 1'b0;
            req.vh = 1'b0;
            req.vg = 1'b0;
        end
    end
endmodule

// File: rtl/apin_bsm_ctrl.sv
module apin_bsm_ctrl
    import apin_pkg::*;
#(
    parameter int unsigned INSTR_W     = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr,
    input  logic               shift_en,
    input  logic               capture_en,
    input  logic               update_en,
    input  logic               scan_in,
    input  logic               cmp_hi,
    output logic               scan_out,
    output logic               en_core_dis,
    output logic               en_vl,
    output logic               en_vh,
    output logic               en_vg,
    output logic               en_ab1,
    output logic               en_ab2,
    output logic               drv_err
);
    apin_mode_e  mode_q, mode_d;
    apin_cells_t applied;
    apin_sw_t    req, sw_q;
    logic        conflict, err_q, dig;

    apin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (cmp_hi),
        .q     (dig)
    );

    apin_scan_cells u_cells (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en   (shift_en),
        .capture_en (capture_en),
        .update_en  (update_en),
        .scan_in    (scan_in),
        .dig_in     (dig),
        .scan_out   (scan_out),
        .applied    (applied)
    );

    apin_sw_decode u_dec (
        .mode     (mode_q),
        .cells    (applied),
        .req      (req),
        .conflict (conflict)
    );

    // Next-state selection from the instruction code
    always_comb begin
        case (instr)
            INSTR_W'(1): mode_d = M_SAMPLE;
            INSTR_W'(2): mode_d = M_EXTEST;
            INSTR_W'(3): mode_d = M_PROBE;
            INSTR_W'(4): mode_d = M_CLAMP;
            INSTR_W'(5): mode_d = M_HIGHZ;
            default:     mode_d = M_FUNC;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= M_FUNC;
        else        mode_q <= mode_d;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_q  <= '0;
            err_q <= 1'b0;
        end else begin
            unique case (mode_q)
                M_CLAMP: begin
                    sw_q.core_dis <= 1'b1;
                end
                default: begin
                    sw_q  <= req;
                    err_q <= conflict;
                end
            endcase
        end
    end

    assign en_core_dis = sw_q.core_dis;
    assign en_vl       = sw_q.vl;
    assign en_vh       = sw_q.vh;
    assign en_vg       = sw_q.vg;
    assign en_ab1      = sw_q.ab1;
    assign en_ab2      = sw_q.ab2;
    assign drv_err     = err_q;

    // R10: at most one reference source
    p_ref_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({en_vl, en_vh, en_vg}));

    // R10: a flagged conflict leaves every reference open
    p_err_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        drv_err |-> !(en_vl || en_vh || en_vg));

    // R6
    p_highz_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_HIGHZ) |=> (en_core_dis && !(en_vl || en_vh || en_vg || en_ab1 || en_ab2)));

    // R7
    p_clamp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_CLAMP) |=> (en_core_dis && $stable({en_vl, en_vh, en_vg, en_ab1, en_ab2})));

    // R8
    p_probe_core_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_PROBE) |=> (!en_core_dis && !(en_vl || en_vh || en_vg) && (en_ab1 == en_ab2)));

    // R9
    p_func_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_FUNC || mode_q == M_SAMPLE) |=>
        !(en_core_dis || en_vl || en_vh || en_vg || en_ab1 || en_ab2 || drv_err));
endmodule

// File: tb/apin_bsm_ctrl_tb_top.sv
`timescale 1ns/1ps
module apin_bsm_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] instr = 3'd0;
    logic       shift_en = 1'b0, capture_en = 1'b0, update_en = 1'b0;
    logic       scan_in = 1'b0, cmp_hi = 1'b0;
    logic       scan_out, en_core_dis, en_vl, en_vh, en_vg, en_ab1, en_ab2, drv_err;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    apin_bsm_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .instr(instr),
        .shift_en(shift_en), .capture_en(capture_en), .update_en(update_en),
        .scan_in(scan_in), .cmp_hi(cmp_hi), .scan_out(scan_out),
        .en_core_dis(en_core_dis), .en_vl(en_vl), .en_vh(en_vh), .en_vg(en_vg),
        .en_ab1(en_ab1), .en_ab2(en_ab2), .drv_err(drv_err)
    );

    // Vector order: core_dis, vl, vh, vg, ab1, ab2, err
    function automatic logic [6:0] outs();
        return {en_core_dis, en_vl, en_vh, en_vg, en_ab1, en_ab2, drv_err};
    endfunction

    task automatic chk(input string req, input logic [6:0] exp);
        n_run++;
        if (outs() !== exp) begin
            n_fail++;
            $display("FAIL %s: enables %b expected %b", req, outs(), exp);
        end
    endtask

    task automatic chk_bit(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: bit %b expected %b", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic [2:0] code);
        @(negedge clk); instr = code;
        repeat (2) @(negedge clk);
    endtask

    task automatic shift_word(input logic c, input logic o, input logic a, input logic b);
        logic [3:0] w;
        w = {c, o, a, b};
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); shift_en = 1'b1; scan_in = w[i];
        end
        @(negedge clk); shift_en = 1'b0; scan_in = 1'b0;
    endtask

    task automatic pulse_update();
        update_en = 1'b1;
        @(negedge clk); update_en = 1'b0;
    endtask

    task automatic load(input logic c, input logic o, input logic a, input logic b);
        shift_word(c, o, a, b);
        pulse_update();
        @(negedge clk);
    endtask

    // Returns {cal, ctl, d1, d2}
    task automatic read_chain(output logic [3:0] bits);
        bits[0] = scan_out;
        for (int k = 1; k < 4; k++) begin
            shift_en = 1'b1;
            @(negedge clk);
            bits[k] = scan_out;
        end
        shift_en = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset", 7'b0000000);
        chk_bit("R1 scan_out", scan_out, 1'b0);
    endtask

    task automatic t_chain();
        logic [3:0] b;
        set_mode(3'd0);
        shift_word(1'b1, 1'b0, 1'b1, 1'b1);
        chk("R3 shift without update", 7'b0000000);
        read_chain(b);
        chk_bit("R2 d2 out", b[0], 1'b1);
        chk_bit("R2 d1 out", b[1], 1'b1);
        chk_bit("R2 ctl out", b[2], 1'b0);
        chk_bit("R2 cal out", b[3], 1'b1);
    endtask

    task automatic t_extest();
        set_mode(3'd2);
        chk("R5 empty cells", 7'b0000000);
        shift_word(1'b0, 1'b1, 1'b0, 1'b0);
        pulse_update();
        chk("R3 one cycle before enables", 7'b0000000);
        @(negedge clk);
        chk("R5 low reference", 7'b1100000);
        load(1'b0, 1'b1, 1'b1, 1'b0);
        chk("R5 high reference", 7'b1010000);
        load(1'b0, 1'b0, 1'b0, 1'b1);
        chk("R5 buses only", 7'b0000110);
        load(1'b1, 1'b0, 1'b1, 1'b0);
        chk("R5 reference ground", 7'b0001000);
    endtask

    task automatic t_conflict();
        load(1'b1, 1'b1, 1'b1, 1'b1);
        chk("R10 vh+vg conflict", 7'b1000111);
        load(1'b1, 1'b1, 1'b0, 1'b0);
        chk("R10 vl+vg conflict", 7'b1000001);
        load(1'b0, 1'b1, 1'b0, 1'b0);
        chk("R10 cleared", 7'b1100000);
    endtask

    task automatic t_clamp();
        load(1'b0, 1'b1, 1'b1, 1'b1);
        chk("R7 before clamp", 7'b1010110);
        set_mode(3'd4);
        chk("R7 entry frozen", 7'b1010110);
        load(1'b0, 1'b1, 1'b0, 1'b0);
        chk("R7 update ignored", 7'b1010110);
        set_mode(3'd2);
        chk("R7 resume decode", 7'b1100000);
    endtask

    task automatic t_highz();
        load(1'b0, 1'b1, 1'b1, 1'b1);
        set_mode(3'd5);
        chk("R6 highz", 7'b1000000);
    endtask

    task automatic t_probe();
        load(1'b1, 1'b1, 1'b0, 1'b1);
        set_mode(3'd3);
        chk("R8 probe bus on", 7'b0000110);
        load(1'b1, 1'b1, 1'b0, 1'b0);
        chk("R8 probe bus off", 7'b0000000);
    endtask

    task automatic t_func();
        load(1'b1, 1'b1, 1'b1, 1'b1);
        set_mode(3'd1);
        chk("R9 sample", 7'b0000000);
        set_mode(3'd0);
        chk("R9 func", 7'b0000000);
        set_mode(3'd7);
        chk("R9 unused code", 7'b0000000);
    endtask

    task automatic t_capture();
        logic [3:0] b;
        set_mode(3'd1);
        load(1'b1, 1'b0, 1'b0, 1'b1);
        cmp_hi = 1'b1;
        repeat (3) @(negedge clk);
        capture_en = 1'b1;
        @(negedge clk); capture_en = 1'b0;
        read_chain(b);
        chk_bit("R4 capture high", b[1], 1'b1);
        chk_bit("R4 applied d2 reloaded", b[0], 1'b1);
        chk_bit("R4 applied cal reloaded", b[3], 1'b1);
        cmp_hi = 1'b0;
        repeat (3) @(negedge clk);
        capture_en = 1'b1;
        @(negedge clk); capture_en = 1'b0;
        read_chain(b);
        chk_bit("R4 capture low", b[1], 1'b0);
    endtask

    task automatic t_cap_upd();
        logic [3:0] b;
        set_mode(3'd2);
        load(1'b0, 1'b1, 1'b0, 1'b0);
        shift_word(1'b0, 1'b1, 1'b1, 1'b1);
        cmp_hi = 1'b1;
        repeat (3) @(negedge clk);
        capture_en = 1'b1; update_en = 1'b1;
        @(negedge clk); capture_en = 1'b0; update_en = 1'b0;
        read_chain(b);
        chk_bit("R4 same-edge old d2", b[0], 1'b0);
        chk_bit("R4 same-edge digitized d1", b[1], 1'b1);
        chk_bit("R4 same-edge old ctl", b[2], 1'b1);
        chk_bit("R4 same-edge old cal", b[3], 1'b0);
        chk("R3 same-edge new enables", 7'b1010110);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_chain();
        t_extest();
        t_conflict();
        t_clamp();
        t_highz();
        t_probe();
        t_func();
        t_capture();
        t_cap_upd();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule